// File: doc/BRIEF.md
# Ring Buffer Block Pointer Unit

This unit keeps the block numbers that decide where incoming CD sectors and subcode frames land in a block-organised ring buffer in external RAM. It has two 9-bit counters. The data counter holds the newest completely decoded data block. The subcode counter holds the newest completely buffered subcode block. The host can load either counter one byte at a time. It sees both counters and both fill targets directly on output ports.

The unit registers the block now being filled, for data and for subcode. Normally that block is the counter plus one, modulo 512. A programmable wrap lets the data ring be shorter than the full range. When the data counter equals a compare value, the next fill goes to a base block instead. When an advance event arrives, the data counter takes the data fill target, so the counter always names a block that was actually written.

Which event advances the data counter depends on the correction mode:
- **Real-time correction:** the data counter advances on each sector sync.
- **Buffer-independent correction:** it advances at the end of the error-detection check, and only when neither error flag is raised.

The subcode counter advances when a subcode block finishes. In follow mode, the subcode fill target is slaved to the data fill target.

Top module: `ring_blkptr`

## Requirements
- R1: While `rst_n` is low, both counters clear to 0 and both fill targets are set to 1.
- R2: A host write with `host_wr` high takes effect at the next edge, according to `host_sel`:
  - 0 loads data counter bits 7:0 from `host_wdata`.
  - 1 loads data counter bit 8 from `host_wdata[0]`.
  - 2 loads subcode counter bits 7:0 from `host_wdata`.
  - 3 loads subcode counter bit 8 from `host_wdata[0]`.
- R3: With `bic_mode` low, a `sync_pulse` loads the data counter with the current `data_tgt`. In this mode `edc_done` has no effect.
- R4: With `bic_mode` high, an `edc_done` with both `sta_err` and `hce_err` low loads the data counter with the current `data_tgt`. In this mode `sync_pulse` has no effect.
- R5: With `bic_mode` high, an `edc_done` while `sta_err` or `hce_err` is high leaves the data counter unchanged.
- R6: `data_tgt` is registered. When the data counter differs from the compare value, `data_tgt` equals the counter plus one, modulo 512. The compare and base values used are those sampled at the previous edge.
- R7: When the data counter equals the `wrap_cmp` value sampled at the previous edge, `data_tgt` equals the `wrap_base` value sampled at that edge.
- R8: A `sub_end` pulse increments the subcode counter by one, modulo 512. The subcode counter has no wrap.
- R9: `sub_tgt` is registered. If `sub_follow` was high at the previous edge, it equals `data_tgt`. Otherwise it equals the subcode counter plus one, modulo 512.
- R10: A host write to a counter byte in the same cycle as that counter's advance event wins. The advance is dropped, and the other counter is unaffected.
- R11: With no host write and no event pulse, both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host byte write strobe |
| host_sel | input | 2 | Byte select: 0 data low, 1 data high, 2 subcode low, 3 subcode high |
| host_wdata | input | 8 | Host write byte |
| bic_mode | input | 1 | 1 = buffer-independent correction, 0 = real-time correction |
| sub_follow | input | 1 | Slave the subcode fill target to the data fill target |
| wrap_cmp | input | 9 | Data counter value at which the fill jumps to the base |
| wrap_base | input | 9 | Block to fill after the compare match |
| sync_pulse | input | 1 | Sector sync event |
| edc_done | input | 1 | End of error-detection check |
| sta_err | input | 1 | Status error flag |
| hce_err | input | 1 | Host correction error flag |
| sub_end | input | 1 | End of subcode block buffering |
| data_cnt | output | 9 | Newest complete data block |
| sub_cnt | output | 9 | Newest complete subcode block |
| data_tgt | output | 9 | Data block being filled |
| sub_tgt | output | 9 | Subcode block being filled |

## Verification
A wrong counter or target value shows at the ports at the first falling edge after the clock edge that produced it. This is because all four block numbers are outputs and the bench compares them every cycle. A badly qualified event shows the same way: a dropped error gate or a misrouted mode select changes `data_cnt` one cycle after the pulse. A wrong wrap or follow decision appears in `data_tgt` or `sub_tgt` as soon as the counter reaches the compare value, and at the latest on the next advance.

// File: rtl/rbp_pkg.sv
// Package: shared types and helpers for the ring buffer block pointer unit.
// Assumes block numbers are wider than one byte and at most two bytes wide.
package rbp_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_DAT_LO = 2'd0,
        SEL_DAT_HI = 2'd1,
        SEL_SUB_LO = 2'd2,
        SEL_SUB_HI = 2'd3
    } host_sel_e;
endpackage

// File: rtl/rbp_evt_qual.sv
// Module: turns raw event pulses, mode bits and host strobes into per-counter
// advance and byte-load enables. A host write to a counter masks that
// counter's advance. Assumes pulses are one cycle wide.
module rbp_evt_qual
    import rbp_pkg::*;
(
    input  logic       bic_mode,
    input  logic       sync_pulse,
    input  logic       edc_done,
    input  logic       sta_err,
    input  logic       hce_err,
    input  logic       sub_end,
    input  logic       host_wr,
    input  logic [1:0] host_sel,
    output logic       data_adv,
    output logic       sub_adv,
    output logic       data_ld_lo,
    output logic       data_ld_hi,
    output logic       sub_ld_lo,
    output logic       sub_ld_hi
);
    logic data_evt;
    logic data_wr;
    logic sub_wr;

    // Decode the host byte select into four load enables.
    always_comb begin
        data_ld_lo = host_wr && (host_sel == SEL_DAT_LO);
        data_ld_hi = host_wr && (host_sel == SEL_DAT_HI);
        sub_ld_lo  = host_wr && (host_sel == SEL_SUB_LO);
        sub_ld_hi  = host_wr && (host_sel == SEL_SUB_HI);
        data_wr    = data_ld_lo || data_ld_hi;
        sub_wr     = sub_ld_lo  || sub_ld_hi;
    end

    // Pick the data advance event by correction mode, gated by error flags.
    always_comb begin
        if (bic_mode)
            data_evt = edc_done && !sta_err && !hce_err;
        else
            data_evt = sync_pulse;
        data_adv = data_evt && !data_wr;
        sub_adv  = sub_end  && !sub_wr;
    end
endmodule

// File: rtl/rbp_blk_counter.sv
// Module: a block number register with host byte loads and an advance load.
// On advance it takes adv_val, which the parent supplies. Host loads beat the
// advance. cnt_nxt is the value the register will take at the next edge.
module rbp_blk_counter
    import rbp_pkg::*;
#(
    parameter int BLK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              adv,
    input  logic [BLK_W-1:0]  adv_val,
    output logic [BLK_W-1:0]  cnt,
    output logic [BLK_W-1:0]  cnt_nxt
);
    localparam int HI_W = BLK_W - BYTE_W;

    // Next-value selection: host bytes first, then advance, else hold.
    always_comb begin
        cnt_nxt = cnt;
        if (ld_lo)
            cnt_nxt[BYTE_W-1:0] = wdata;
        else if (ld_hi)
            cnt_nxt[BLK_W-1:BYTE_W] = wdata[HI_W-1:0];
        else if (adv)
            cnt_nxt = adv_val;
    end

    // State register with synchronous reset to block 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end
endmodule

// File: rtl/rbp_tgt_gen.sv
// Module: registers the fill targets from the counters' next values.
// For data, the target is the successor or, on a compare match, the wrap base.
// For subcode, the target is the successor or the data target in follow mode.
// Both reset to block 1.
module rbp_tgt_gen #(
    parameter int BLK_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] data_nxt,
    input  logic [BLK_W-1:0] sub_nxt,
    input  logic [BLK_W-1:0] wrap_cmp,
    input  logic [BLK_W-1:0] wrap_base,
    input  logic             sub_follow,
    output logic [BLK_W-1:0] data_tgt,
    output logic [BLK_W-1:0] sub_tgt
);
    localparam logic [BLK_W-1:0] ONE = BLK_W'(1);

    logic [BLK_W-1:0] data_tgt_d;
    logic [BLK_W-1:0] sub_tgt_d;

    // Compute the successor blocks, applying the wrap and follow choices.
    always_comb begin
        data_tgt_d = (data_nxt == wrap_cmp) ? wrap_base : data_nxt + ONE;
        sub_tgt_d  = sub_follow ? data_tgt_d : sub_nxt + ONE;
    end

    // Target registers, reset to the block after block 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_tgt <= ONE;
            sub_tgt  <= ONE;
        end else begin
            data_tgt <= data_tgt_d;
            sub_tgt  <= sub_tgt_d;
        end
    end
endmodule

// File: rtl/ring_blkptr.sv
// Module: top of the ring buffer block pointer unit. It wires event
// qualification, one counter instance per stream, and target generation.
// The data counter advances onto its registered fill target. The subcode
// counter steps by one. Assumes synchronous single-cycle event pulses.
module ring_blkptr
    import rbp_pkg::*;
#(
    parameter int BLK_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [1:0]       host_sel,
    input  logic [7:0]       host_wdata,
    input  logic             bic_mode,
    input  logic             sub_follow,
    input  logic [BLK_W-1:0] wrap_cmp,
    input  logic [BLK_W-1:0] wrap_base,
    input  logic             sync_pulse,
    input  logic             edc_done,
    input  logic             sta_err,
    input  logic             hce_err,
    input  logic             sub_end,
    output logic [BLK_W-1:0] data_cnt,
    output logic [BLK_W-1:0] sub_cnt,
    output logic [BLK_W-1:0] data_tgt,
    output logic [BLK_W-1:0] sub_tgt
);
    localparam int NSTREAM = 2;
    localparam int S_DATA  = 0;
    localparam int S_SUB   = 1;

    logic [NSTREAM-1:0] adv;
    logic [NSTREAM-1:0] ld_lo;
    logic [NSTREAM-1:0] ld_hi;
    logic [BLK_W-1:0]   adv_val [NSTREAM];
    logic [BLK_W-1:0]   cnt     [NSTREAM];
    logic [BLK_W-1:0]   cnt_nxt [NSTREAM];

    rbp_evt_qual u_qual (
        .bic_mode   (bic_mode),
        .sync_pulse (sync_pulse),
        .edc_done   (edc_done),
        .sta_err    (sta_err),
        .hce_err    (hce_err),
        .sub_end    (sub_end),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .data_adv   (adv[S_DATA]),
        .sub_adv    (adv[S_SUB]),
        .data_ld_lo (ld_lo[S_DATA]),
        .data_ld_hi (ld_hi[S_DATA]),
        .sub_ld_lo  (ld_lo[S_SUB]),
        .sub_ld_hi  (ld_hi[S_SUB])
    );

    // Advance values: data lands on its fill target, subcode steps by one.
    always_comb begin
        adv_val[S_DATA] = data_tgt;
        adv_val[S_SUB]  = cnt[S_SUB] + BLK_W'(1);
    end

    for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
        rbp_blk_counter #(.BLK_W(BLK_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_lo   (ld_lo[s]),
            .ld_hi   (ld_hi[s]),
            .wdata   (host_wdata),
            .adv     (adv[s]),
            .adv_val (adv_val[s]),
            .cnt     (cnt[s]),
            .cnt_nxt (cnt_nxt[s])
        );
    end

    rbp_tgt_gen #(.BLK_W(BLK_W)) u_tgt (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_nxt   (cnt_nxt[S_DATA]),
        .sub_nxt    (cnt_nxt[S_SUB]),
        .wrap_cmp   (wrap_cmp),
        .wrap_base  (wrap_base),
        .sub_follow (sub_follow),
        .data_tgt   (data_tgt),
        .sub_tgt    (sub_tgt)
    );

    // Drive the counter outputs from the stream array.
    always_comb begin
        data_cnt = cnt[S_DATA];
        sub_cnt  = cnt[S_SUB];
    end
endmodule

// File: rtl/rbp_chk.sv
// Module: property checker for ring_blkptr, bound to every instance.
// It watches only the top-level ports.
module rbp_chk #(
    parameter int BLK_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic [1:0]       host_sel,
    input logic [7:0]       host_wdata,
    input logic             bic_mode,
    input logic             sub_follow,
    input logic [BLK_W-1:0] wrap_cmp,
    input logic [BLK_W-1:0] wrap_base,
    input logic             sync_pulse,
    input logic             edc_done,
    input logic             sta_err,
    input logic             hce_err,
    input logic             sub_end,
    input logic [BLK_W-1:0] data_cnt,
    input logic [BLK_W-1:0] sub_cnt,
    input logic [BLK_W-1:0] data_tgt,
    input logic [BLK_W-1:0] sub_tgt
);
    logic dwr;
    logic swr;

    // Host write flags for each counter.
    always_comb begin
        dwr = host_wr && !host_sel[1];
        swr = host_wr &&  host_sel[1];
    end

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (data_cnt == '0 && sub_cnt == '0 &&
                           data_tgt == BLK_W'(1) && sub_tgt == BLK_W'(1)));

    p_host_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd0) |=> data_cnt[7:0] == $past(host_wdata));

    p_host_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd3) |=> sub_cnt[BLK_W-1] == $past(host_wdata[0]));

    p_rtc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bic_mode && sync_pulse && !dwr) |=> data_cnt == $past(data_tgt));

    p_bic_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bic_mode && edc_done && !sta_err && !hce_err && !dwr) |=> data_cnt == $past(data_tgt));

    p_bic_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bic_mode && edc_done && (sta_err || hce_err) && !dwr) |=> $stable(data_cnt));

    p_succ_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && data_cnt != $past(wrap_cmp)) |-> data_tgt == data_cnt + BLK_W'(1));

    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && data_cnt == $past(wrap_cmp)) |-> data_tgt == $past(wrap_base));

    p_sub_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_end && !swr) |=> sub_cnt == $past(sub_cnt) + BLK_W'(1));

    p_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sub_follow) |-> sub_tgt == data_tgt);

    p_host_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd2 && sub_end) |=> sub_cnt[7:0] == $past(host_wdata));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !sync_pulse && !edc_done && !sub_end) |=> ($stable(data_cnt) && $stable(sub_cnt)));
endmodule

bind ring_blkptr rbp_chk #(.BLK_W(BLK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .bic_mode   (bic_mode),
    .sub_follow (sub_follow),
    .wrap_cmp   (wrap_cmp),
    .wrap_base  (wrap_base),
    .sync_pulse (sync_pulse),
    .edc_done   (edc_done),
    .sta_err    (sta_err),
    .hce_err    (hce_err),
    .sub_end    (sub_end),
    .data_cnt   (data_cnt),
    .sub_cnt    (sub_cnt),
    .data_tgt   (data_tgt),
    .sub_tgt    (sub_tgt)
);

// File: tb/sim_ring_blkptr.sv
// Bench: a behavioural reference model is updated at each rising edge.
// All four outputs are compared with it at every falling edge.
module sim_ring_blkptr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic       bic_mode = 1'b0;
    logic       sub_follow = 1'b0;
    logic [8:0] wrap_cmp = 9'h1FF;
    logic [8:0] wrap_base = 9'h000;
    logic       sync_pulse = 1'b0;
    logic       edc_done = 1'b0;
    logic       sta_err = 1'b0;
    logic       hce_err = 1'b0;
    logic       sub_end = 1'b0;
    logic [8:0] data_cnt;
    logic [8:0] sub_cnt;
    logic [8:0] data_tgt;
    logic [8:0] sub_tgt;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string phase = "R1 reset";

    int md = 0;
    int ms = 0;
    int mdt = 1;
    int mst = 1;

    always #4 clk = ~clk;

    ring_blkptr u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .bic_mode(bic_mode), .sub_follow(sub_follow),
        .wrap_cmp(wrap_cmp), .wrap_base(wrap_base), .sync_pulse(sync_pulse),
        .edc_done(edc_done), .sta_err(sta_err), .hce_err(hce_err),
        .sub_end(sub_end), .data_cnt(data_cnt), .sub_cnt(sub_cnt),
        .data_tgt(data_tgt), .sub_tgt(sub_tgt)
    );

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        int nd;
        int ns;
        bit dev;
        cyc++;
        if (!rst_n) begin
            md = 0; ms = 0; mdt = 1; mst = 1;
        end else begin
            nd = md;
            ns = ms;
            dev = bic_mode ? (edc_done && !sta_err && !hce_err) : sync_pulse;
            if (host_wr && host_sel == 2'd0)      nd = (md & 32'h100) | int'(host_wdata);
            else if (host_wr && host_sel == 2'd1) nd = (md & 32'hFF) | (int'(host_wdata[0]) << 8);
            else if (dev)                          nd = mdt;
            if (host_wr && host_sel == 2'd2)      ns = (ms & 32'h100) | int'(host_wdata);
            else if (host_wr && host_sel == 2'd3) ns = (ms & 32'hFF) | (int'(host_wdata[0]) << 8);
            else if (sub_end)                      ns = (ms + 1) % 512;
            mdt = (nd == int'(wrap_cmp)) ? int'(wrap_base) : (nd + 1) % 512;
            mst = sub_follow ? mdt : (ns + 1) % 512;
            md = nd;
            ms = ns;
        end
    end

    task automatic compare();
        n_cmp++;
        if (int'(data_cnt) != md || int'(sub_cnt) != ms ||
            int'(data_tgt) != mdt || int'(sub_tgt) != mst) begin
            n_bad++;
            $display("FAIL %s: got dc=%0d sc=%0d dt=%0d st=%0d exp dc=%0d sc=%0d dt=%0d st=%0d",
                     phase, data_cnt, sub_cnt, data_tgt, sub_tgt, md, ms, mdt, mst);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        host_wr = 0; sync_pulse = 0; edc_done = 0; sub_end = 0;
        sta_err = 0; hce_err = 0;
    endtask

    task automatic hwrite(input logic [1:0] sel, input logic [7:0] val);
        host_wr = 1; host_sel = sel; host_wdata = val;
        tick();
        host_wr = 0;
        tick();
    endtask

    task automatic pulse_sync(input int n);
        for (int i = 0; i < n; i++) begin
            sync_pulse = 1; tick(); sync_pulse = 0; tick();
        end
    endtask

    task automatic pulse_edc(input logic se, input logic he);
        edc_done = 1; sta_err = se; hce_err = he; tick();
        idle(); tick();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: got cycle %0d exp finish before 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        // R1 reset state
        tick(); tick(); tick();
        rst_n = 1;
        tick();

        // R3: sync advances in real-time mode; edc_done is ignored
        phase = "R3 rtc sync advance";
        pulse_sync(3);
        pulse_edc(0, 0);
        pulse_edc(0, 0);

        // R2: host byte loads
        phase = "R2 host byte write";
        hwrite(2'd0, 8'hFE);
        hwrite(2'd1, 8'h01);
        hwrite(2'd2, 8'h34);
        hwrite(2'd3, 8'hFF);

        // R6: successor and natural wrap from 511 to 0
        phase = "R6 successor mod 512";
        pulse_sync(3);

        // R7: programmable wrap
        phase = "R7 wrap to base";
        wrap_cmp = 9'd5; wrap_base = 9'd100;
        hwrite(2'd1, 8'h00);
        hwrite(2'd0, 8'd3);
        pulse_sync(4);
        wrap_cmp = 9'd101; wrap_base = 9'd7;
        tick();
        pulse_sync(3);

        // R4: buffer-independent mode, clean check advances, sync ignored
        phase = "R4 bic advance";
        bic_mode = 1;
        pulse_edc(0, 0);
        pulse_sync(2);
        pulse_edc(0, 0);

        // R5: errors suppress the advance
        phase = "R5 bic error gate";
        pulse_edc(1, 0);
        pulse_edc(0, 1);
        pulse_edc(1, 1);

        // R8: subcode step including 511 -> 0
        phase = "R8 subcode step";
        hwrite(2'd2, 8'hFE);
        hwrite(2'd3, 8'h01);
        for (int i = 0; i < 3; i++) begin
            sub_end = 1; tick(); sub_end = 0; tick();
        end

        // R9: follow mode slaves the subcode target
        phase = "R9 subcode follow";
        sub_follow = 1;
        tick();
        pulse_edc(0, 0);
        sub_end = 1; tick(); sub_end = 0; tick();
        sub_follow = 0;
        tick();

        // R10: a host write beats a same-cycle advance
        phase = "R10 host write priority";
        bic_mode = 0;
        host_wr = 1; host_sel = 2'd0; host_wdata = 8'h40; sync_pulse = 1; sub_end = 1;
        tick(); idle(); tick();
        host_wr = 1; host_sel = 2'd2; host_wdata = 8'h22; sync_pulse = 1; sub_end = 1;
        tick(); idle(); tick();

        // R11: idle holds
        phase = "R11 idle hold";
        for (int i = 0; i < 5; i++) tick();

        // Mixed stream against the model
        phase = "R6 mixed stream";
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            sync_pulse = lf[0]; edc_done = lf[1]; sta_err = lf[2] & lf[3];
            hce_err = lf[4] & lf[5]; sub_end = lf[6];
            host_wr = (lf[9:7] == 3'd0); host_sel = lf[11:10]; host_wdata = lf[15:8];
            if (lf[15:12] == 4'd0) bic_mode = ~bic_mode;
            if (lf[14:11] == 4'd1) sub_follow = ~sub_follow;
            if (lf[13:10] == 4'd2) begin wrap_cmp = {1'b0, lf[7:0]}; wrap_base = {1'b1, lf[15:8]}; end
            tick();
        end
        idle();
        tick();

        // R1: reset again mid-run
        phase = "R1 reset";
        rst_n = 0; tick(); rst_n = 1; tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule